// File: doc/BRIEF.md
# Dual-Pointer Metadata Lookup Table

This block is a small per-core table of 16-bit metadata words: tensor shape descriptors, size descriptors and scale factors. A preload port fills entries, one write per cycle, before the instructions that need them are issued. Compute never writes the table.

An instruction decoder issues a lookup carrying two 6-bit pointers taken from one instruction, one for shape and one for size. Both pointers index the same 64-entry table. Both words come back together on the next cycle from registered outputs, with a valid flag beside them.

Each entry carries a written bit that reset clears. Looking up an entry that has not been written returns zero and sets an error flag. That flag stays set until the next reset.

Top module: `ctbl_ptr_lookup`

## Requirements
- R1: While reset is held, and on the first sampling after it is released, `rd_valid`, `err_flag`, `shape_data` and `size_data` are all zero. Every entry counts as unwritten after reset.
- R2: A cycle with `rd_req` high makes `rd_valid` high one cycle later. A cycle with `rd_req` low makes `rd_valid` low one cycle later.
- R3: The two pointers resolve independently in the same lookup. `shape_data` returns the entry at `shape_ptr` and `size_data` returns the entry at `size_ptr`, including when both pointers are equal.
- R4: A cycle with `wr_en` high stores `wr_data` at `wr_addr`. The stored word is returned by lookups issued in any later cycle. A later write to the same entry replaces it, and back-to-back writes on consecutive cycles are all kept.
- R5: A write and a lookup of the same entry in the same cycle return the contents from before the write (read-first). That also applies when the entry was unwritten, which gives zero and an error.
- R6: A lookup pointer that names an unwritten entry returns zero on its own data output, independently of the other pointer, and sets `err_flag` one cycle later.
- R7: Once set, `err_flag` stays high through later successful lookups and idle cycles until reset.
- R8: In a cycle with `rd_req` low, `shape_data` and `size_data` keep their previous values.
- R9: When `wr_en` is low, `wr_addr` and `wr_data` leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | 6 | Preload entry index |
| wr_data | input | 16 | Preload data word |
| rd_req | input | 1 | Lookup request |
| shape_ptr | input | 6 | Shape pointer of the lookup |
| size_ptr | input | 6 | Size pointer of the lookup |
| shape_data | output | 16 | Entry named by the shape pointer |
| size_data | output | 16 | Entry named by the size pointer |
| rd_valid | output | 1 | Lookup result valid |
| err_flag | output | 1 | Sticky flag: an unwritten entry was looked up |

## Verification
Every result of this block is due exactly one clock after the cycle that carries its stimulus: the two data words, `rd_valid`, and the rise of `err_flag`. A write is seen by lookups issued in the following cycle or later. The bench drives each vector on a falling edge and samples on the next falling edge, which is exactly one rising edge later. Expected values in the vector table therefore belong to the lookup in that same vector. Read-first cases are covered by rows that write and look up the same index in one row and expect the older contents.

// File: rtl/ctbl_pkg.sv
package ctbl_pkg;
    // Default geometry of the metadata table
    localparam int CT_DEPTH  = 64;
    localparam int CT_DATA_W = 16;
endpackage

// File: rtl/ctbl_store.sv
module ctbl_store #(
    parameter int DEPTH  = ctbl_pkg::CT_DEPTH,
    parameter int DATA_W = ctbl_pkg::CT_DATA_W,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr_a,
    input  logic [PTR_W-1:0]  rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    // Next contents: only the addressed word changes on a strobe
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    // Reads see the pre-write contents (read-first)
    assign rd_data_a = mem_q[rd_addr_a];
    assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/ctbl_vmask.sv
module ctbl_vmask #(
    parameter int DEPTH = ctbl_pkg::CT_DEPTH,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [PTR_W-1:0] chk_a,
    input  logic [PTR_W-1:0] chk_b,
    output logic             hit_a,
    output logic             hit_b
);
    logic [DEPTH-1:0] vld_d;
    logic [DEPTH-1:0] vld_q;

    // One written bit per entry; it is set by a write and cleared only by reset
    for (genvar g = 0; g < DEPTH; g++) begin : g_bit
        always_comb begin
            vld_d[g] = vld_q[g] | (wr_en && (wr_addr == PTR_W'(g)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign hit_a = vld_q[chk_a];
    assign hit_b = vld_q[chk_b];

    AST_MARK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_addr)]);  // R4
endmodule

// File: rtl/ctbl_ptr_lookup.sv
module ctbl_ptr_lookup #(
    parameter int DEPTH  = ctbl_pkg::CT_DEPTH,
    parameter int DATA_W = ctbl_pkg::CT_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_req,
    input  logic [$clog2(DEPTH)-1:0] shape_ptr,
    input  logic [$clog2(DEPTH)-1:0] size_ptr,
    output logic [DATA_W-1:0]        shape_data,
    output logic [DATA_W-1:0]        size_data,
    output logic                     rd_valid,
    output logic                     err_flag
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] shape;
        logic [DATA_W-1:0] size;
        logic              vld;
        logic              err;
    } out_t;

    out_t out_d, out_q;

    logic [DATA_W-1:0] raw_shape, raw_size;
    logic              hit_shape, hit_size;

    ctbl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (shape_ptr),
        .rd_addr_b (size_ptr),
        .rd_data_a (raw_shape),
        .rd_data_b (raw_size)
    );

    ctbl_vmask #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_vmask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .chk_a   (shape_ptr),
        .chk_b   (size_ptr),
        .hit_a   (hit_shape),
        .hit_b   (hit_size)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = rd_req;
        if (rd_req) begin
            out_d.shape = hit_shape ? raw_shape : '0;
            out_d.size  = hit_size  ? raw_size  : '0;
            if (!hit_shape || !hit_size) out_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign shape_data = out_q.shape;
    assign size_data  = out_q.size;
    assign rd_valid   = out_q.vld;
    assign err_flag   = out_q.err;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);  // R2
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);  // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> ($stable(shape_data) && $stable(size_data)));  // R8
    AST_MISS_ZERO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !hit_shape) |=> (shape_data == '0));  // R6
    AST_MISS_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !hit_size) |=> (size_data == '0));  // R6
    AST_MISS_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (!hit_shape || !hit_size)) |=> err_flag);  // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);  // R7
endmodule

// File: tb/sim_ctbl_ptr_lookup.sv
module sim_ctbl_ptr_lookup;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [5:0]  shape_ptr = '0;
    logic [5:0]  size_ptr = '0;
    logic [15:0] shape_data, size_data;
    logic        rd_valid, err_flag;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctbl_ptr_lookup u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .shape_ptr(shape_ptr), .size_ptr(size_ptr),
        .shape_data(shape_data), .size_data(size_data),
        .rd_valid(rd_valid), .err_flag(err_flag)
    );

    typedef struct packed {
        logic        we;
        logic [5:0]  wa;
        logic [15:0] wd;
        logic        rq;
        logic [5:0]  sp;
        logic [5:0]  zp;
        logic        ev;
        logic [15:0] es;
        logic [15:0] ez;
        logic        ee;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // we wa   wd        rq sp  zp   ev es        ez        ee
        '{1'b1, 6'd5,  16'h1234, 1'b0, 6'd0,  6'd0,  1'b0, 16'h0000, 16'h0000, 1'b0}, // R4 write
        '{1'b1, 6'd9,  16'hBEEF, 1'b1, 6'd5,  6'd5,  1'b1, 16'h1234, 16'h1234, 1'b0}, // R3 equal ptrs
        '{1'b1, 6'd63, 16'hA5A5, 1'b1, 6'd5,  6'd9,  1'b1, 16'h1234, 16'hBEEF, 1'b0}, // R3 R4 back-to-back
        '{1'b1, 6'd0,  16'h0F0F, 1'b1, 6'd63, 6'd9,  1'b1, 16'hA5A5, 16'hBEEF, 1'b0}, // R3 top index
        '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd1,  6'd2,  1'b0, 16'hA5A5, 16'hBEEF, 1'b0}, // R2 R8 idle hold
        '{1'b1, 6'd5,  16'h7777, 1'b1, 6'd5,  6'd0,  1'b1, 16'h1234, 16'h0F0F, 1'b0}, // R5 read-first
        '{1'b0, 6'd5,  16'hFFFF, 1'b1, 6'd5,  6'd5,  1'b1, 16'h7777, 16'h7777, 1'b0}, // R4 R9 overwrite kept
        '{1'b1, 6'd10, 16'hC3C3, 1'b1, 6'd10, 6'd0,  1'b1, 16'h0000, 16'h0F0F, 1'b1}, // R5 R6 unwritten
        '{1'b0, 6'd0,  16'h0000, 1'b1, 6'd10, 6'd63, 1'b1, 16'hC3C3, 16'hA5A5, 1'b1}, // R7 sticky
        '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  6'd0,  1'b0, 16'hC3C3, 16'hA5A5, 1'b1}  // R7 R8 idle
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [5:0] wa, input logic [15:0] wd,
                         input logic rq, input logic [5:0] sp, input logic [5:0] zp);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_req = rq; shape_ptr = sp; size_ptr = zp;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
        chk("R1", "err_flag in reset", 32'(err_flag), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "shape_data after reset", 32'(shape_data), 32'd0);
        chk("R1", "size_data after reset", 32'(size_data), 32'd0);
        chk("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);

        // Vector table: each row's results are due one clock later
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].rq, VECS[i].sp, VECS[i].zp);
            @(negedge clk);
            chk("R2", $sformatf("vec%0d rd_valid", i), 32'(rd_valid), 32'(VECS[i].ev));
            chk("R3", $sformatf("vec%0d shape_data", i), 32'(shape_data), 32'(VECS[i].es));
            chk("R3", $sformatf("vec%0d size_data", i), 32'(size_data), 32'(VECS[i].ez));
            chk("R7", $sformatf("vec%0d err_flag", i), 32'(err_flag), 32'(VECS[i].ee));
        end

        // R1: mid-run reset clears outputs and written bits
        drive(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 6'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "err_flag cleared by reset", 32'(err_flag), 32'd0);
        chk("R1", "shape_data cleared by reset", 32'(shape_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b0, 6'd0, 16'h0, 1'b1, 6'd5, 6'd9);
        @(negedge clk);
        chk("R1", "old entry unwritten after reset", 32'(shape_data), 32'd0);
        chk("R6", "err after lookup of reset entry", 32'(err_flag), 32'd1);

        // R6: only the size pointer misses
        rst_n = 1'b0;
        drive(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 6'd3, 16'h0042, 1'b0, 6'd0, 6'd0);
        @(negedge clk);
        chk("R6", "err stays low without lookup", 32'(err_flag), 32'd0);
        drive(1'b0, 6'd0, 16'h0, 1'b1, 6'd3, 6'd4);
        @(negedge clk);
        chk("R6", "hit shape beside miss", 32'(shape_data), 32'h0042);
        chk("R6", "miss size returns zero", 32'(size_data), 32'd0);
        chk("R6", "err on size miss", 32'(err_flag), 32'd1);
        chk("R2", "valid on missing lookup", 32'(rd_valid), 32'd1);

        // R9: strobe low with changing address/data leaves entry 3 intact
        drive(1'b0, 6'd3, 16'hDEAD, 1'b0, 6'd0, 6'd0);
        @(negedge clk);
        drive(1'b0, 6'd3, 16'hBEEF, 1'b1, 6'd3, 6'd3);
        @(negedge clk);
        chk("R9", "entry unchanged without strobe", 32'(size_data), 32'h0042);

        drive(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 6'd0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule